// File: doc/BRIEF.md
# Multi-Mode Gain Control Selector

This block sits between a small set of shared control pins and the gain stage of a variable-gain amplifier. A two-bit mode input chooses which of three control front ends owns the gain code: a parallel bus with a latch, a serial register interface, or an up/down stepping interface. The serial and up/down front ends are separate blocks. This block gives them the synchronized pin values they need and takes back a gain code with a one-cycle load strobe. The parallel front end lives inside this block. The result is a single registered 6-bit gain code.

All pin inputs (mode, shared pins, power-mode and power-up) cross into the system clock domain through two-flop synchronizers. A gain code is held until the currently selected front end produces an update. A change of mode on its own therefore never disturbs the gain. While power-up is deasserted, the output is forced to the all-ones code, which is the lowest gain. Updates that arrive during that time are still tracked, so the tracked code is what appears once power returns.

Top module: `gain_iface_sel`

## Requirements
- R1: The synchronized mode code 00 selects the parallel front end, 01 selects the serial front end, and both 10 and 11 select the up/down front end. Load strobes or bus activity from a front end that is not selected leave `gain_o` unchanged.
- R2: In parallel mode, while the latch pin `shared_pins[6]` is low, `gain_o` follows `shared_pins[5:0]`. A change on those pins appears on `gain_o` exactly 4 clock edges later (two synchronizer edges, one capture edge, one output edge).
- R3: In parallel mode, a rising edge on the latch pin captures the bus value present with it. While the latch pin stays high, later bus changes do not reach `gain_o`. When the latch pin returns low, `gain_o` follows the bus again.
- R4: `spi_pins_o` equals the synchronized `shared_pins[2:0]` only in mode 01, and `updn_pins_o` equals the synchronized `shared_pins[3:0]` only in modes 10 and 11. An output that is not selected reads zero. A pin change reaches the routed output 2 clock edges later.
- R5: In serial mode, a `spi_load` pulse loads `spi_gain` into `gain_o` at the same clock edge that samples the pulse.
- R6: In either up/down mode, an `updn_load` pulse loads `updn_gain` into `gain_o` at the same clock edge that samples the pulse.
- R7: After a change of mode, `gain_o` keeps its last code until the newly selected front end updates it.
- R8: While the synchronized power-up input is low, `gain_o` is 6'b111111. Updates accepted in that time are retained, and the last of them appears on `gain_o` once power-up returns high.
- R9: `lowpwr_o` and `pwrup_o` reproduce `pm_pin` and `pwup_pin` exactly 2 clock edges later, in every mode.
- R10: Synchronous reset drives `gain_o` to 6'b111111 and drives `spi_pins_o`, `updn_pins_o`, `lowpwr_o` and `pwrup_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_pins | input | 2 | Asynchronous front-end select pins |
| shared_pins | input | 7 | Asynchronous shared control pins; the function of each depends on the mode |
| pm_pin | input | 1 | Asynchronous power-mode pin (high = low-power) |
| pwup_pin | input | 1 | Asynchronous power-up pin |
| spi_gain | input | 6 | Gain code from the serial front end |
| spi_load | input | 1 | One-cycle load strobe from the serial front end |
| updn_gain | input | 6 | Gain code from the up/down front end |
| updn_load | input | 1 | One-cycle load strobe from the up/down front end |
| gain_o | output | 6 | Registered gain code to the gain stage |
| spi_pins_o | output | 3 | Synchronized pins routed to the serial front end |
| updn_pins_o | output | 4 | Synchronized pins routed to the up/down front end |
| lowpwr_o | output | 1 | Synchronized power-mode select |
| pwrup_o | output | 1 | Synchronized power-up |

## Verification
A wrong selection or hold state shows up as `gain_o` taking a code from a front end that should be ignored. With the latch held high or after a mode change, this appears on the first edge after the strobe or bus change that should have been blocked. A stuck parallel capture register shows as `gain_o` failing to track the bus exactly four edges after a change. A power-forcing fault shows one edge after the synchronized power-up falls, and a lost retained code shows one edge after it rises. Routing and power-pin faults appear on the dedicated outputs two edges after the pin change.

// File: rtl/gsel_pkg.sv
package gsel_pkg;

    localparam int GAIN_W_DEF  = 6;
    localparam int SPI_PIN_N   = 3;
    localparam int UPDN_PIN_N  = 4;
    localparam int MODE_W      = 2;

    typedef enum logic [1:0] {
        SRC_PAR  = 2'd0,
        SRC_SPI  = 2'd1,
        SRC_UPDN = 2'd2
    } src_e;

    function automatic src_e decode_mode(input logic [MODE_W-1:0] m);
        case (m)
            2'b00:   return SRC_PAR;
            2'b01:   return SRC_SPI;
            default: return SRC_UPDN;
        endcase
    endfunction

    typedef struct packed {
        logic lowpwr;
        logic pwrup;
    } pwr_t;

endpackage

// File: rtl/gsel_sync.sv
module gsel_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gsel_pin_route.sv
module gsel_pin_route
    import gsel_pkg::*;
#(
    parameter int GAIN_W = GAIN_W_DEF,
    localparam int PIN_W = GAIN_W + 1
) (
    input  src_e                  src,
    input  logic [PIN_W-1:0]      pins,
    output logic [GAIN_W-1:0]     par_bus,
    output logic                  par_latch,
    output logic [SPI_PIN_N-1:0]  spi_pins,
    output logic [UPDN_PIN_N-1:0] updn_pins
);
    // The parallel front end always sees the bus; its updates are gated later.
    assign par_bus   = pins[GAIN_W-1:0];
    assign par_latch = pins[GAIN_W];

    always_comb begin
        spi_pins  = '0;
        updn_pins = '0;
        case (src)
            SRC_SPI:  spi_pins  = pins[SPI_PIN_N-1:0];
            SRC_UPDN: updn_pins = pins[UPDN_PIN_N-1:0];
            default: ;
        endcase
    end
endmodule

// File: rtl/gsel_par_latch.sv
module gsel_par_latch #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] bus,
    input  logic         latch,
    output logic [W-1:0] code,
    output logic         upd
);
    logic latch_q;
    logic load;

    // Transparent while low; the rising-edge cycle still loads, then it holds.
    assign load = !latch || !latch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= 1'b0;
            upd     <= 1'b0;
            code    <= '0;
        end else begin
            latch_q <= latch;
            upd     <= load;
            if (load) code <= bus;
        end
    end
endmodule

// File: rtl/gsel_gain_reg.sv
module gsel_gain_reg
    import gsel_pkg::*;
#(
    parameter int GAIN_W = GAIN_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  src_e              src,
    input  logic              pwrup,
    input  logic [GAIN_W-1:0] par_code,
    input  logic              par_upd,
    input  logic [GAIN_W-1:0] spi_code,
    input  logic              spi_upd,
    input  logic [GAIN_W-1:0] updn_code,
    input  logic              updn_upd,
    output logic [GAIN_W-1:0] gain
);
    localparam logic [GAIN_W-1:0] MIN_GAIN = '1;

    logic [GAIN_W-1:0] code_q;
    logic [GAIN_W-1:0] code_nxt;

    always_comb begin
        code_nxt = code_q;
        case (src)
            SRC_PAR:  if (par_upd)  code_nxt = par_code;
            SRC_SPI:  if (spi_upd)  code_nxt = spi_code;
            default:  if (updn_upd) code_nxt = updn_code;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= MIN_GAIN;
            gain   <= MIN_GAIN;
        end else begin
            code_q <= code_nxt;
            gain   <= pwrup ? code_nxt : MIN_GAIN;
        end
    end
endmodule

// File: rtl/gain_iface_sel.sv
module gain_iface_sel
    import gsel_pkg::*;
#(
    parameter int GAIN_W      = GAIN_W_DEF,
    parameter int SYNC_STAGES = 2,
    localparam int PIN_W      = GAIN_W + 1,
    localparam int SYNC_W     = MODE_W + PIN_W + $bits(pwr_t)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [MODE_W-1:0]     mode_pins,
    input  logic [PIN_W-1:0]      shared_pins,
    input  logic                  pm_pin,
    input  logic                  pwup_pin,
    input  logic [GAIN_W-1:0]     spi_gain,
    input  logic                  spi_load,
    input  logic [GAIN_W-1:0]     updn_gain,
    input  logic                  updn_load,
    output logic [GAIN_W-1:0]     gain_o,
    output logic [SPI_PIN_N-1:0]  spi_pins_o,
    output logic [UPDN_PIN_N-1:0] updn_pins_o,
    output logic                  lowpwr_o,
    output logic                  pwrup_o
);
    logic [SYNC_W-1:0] sync_d, sync_q;
    logic [MODE_W-1:0] mode_s;
    logic [PIN_W-1:0]  pins_s;
    pwr_t              pwr_s;
    src_e              src_s;

    logic [GAIN_W-1:0] par_bus;
    logic              par_latch;
    logic [GAIN_W-1:0] par_code;
    logic              par_upd;

    assign sync_d = {mode_pins, shared_pins, pm_pin, pwup_pin};

    gsel_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sync_d),
        .q   (sync_q)
    );

    assign {mode_s, pins_s, pwr_s} = sync_q;
    assign src_s = decode_mode(mode_s);

    gsel_pin_route #(.GAIN_W(GAIN_W)) u_route (
        .src       (src_s),
        .pins      (pins_s),
        .par_bus   (par_bus),
        .par_latch (par_latch),
        .spi_pins  (spi_pins_o),
        .updn_pins (updn_pins_o)
    );

    gsel_par_latch #(.W(GAIN_W)) u_par (
        .clk   (clk),
        .rst   (rst),
        .bus   (par_bus),
        .latch (par_latch),
        .code  (par_code),
        .upd   (par_upd)
    );

    gsel_gain_reg #(.GAIN_W(GAIN_W)) u_gain (
        .clk       (clk),
        .rst       (rst),
        .src       (src_s),
        .pwrup     (pwr_s.pwrup),
        .par_code  (par_code),
        .par_upd   (par_upd),
        .spi_code  (spi_gain),
        .spi_upd   (spi_load),
        .updn_code (updn_gain),
        .updn_upd  (updn_load),
        .gain      (gain_o)
    );

    assign lowpwr_o = pwr_s.lowpwr;
    assign pwrup_o  = pwr_s.pwrup;
endmodule

// File: rtl/gain_iface_sel_chk.sv
module gain_iface_sel_chk
    import gsel_pkg::*;
#(
    parameter int GAIN_W = GAIN_W_DEF
) (
    input logic              clk,
    input logic              rst,
    input src_e              src,
    input logic              par_upd,
    input logic              spi_load,
    input logic [GAIN_W-1:0] spi_gain,
    input logic              updn_load,
    input logic [GAIN_W-1:0] updn_gain,
    input logic              pwrup_o,
    input logic [GAIN_W-1:0] gain_o
);
    logic no_upd;
    assign no_upd = (src == SRC_PAR  && !par_upd)  ||
                    (src == SRC_SPI  && !spi_load) ||
                    (src == SRC_UPDN && !updn_load);

    AST_SPI_LOAD: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_SPI && spi_load && pwrup_o) |=> gain_o == $past(spi_gain)); // R5

    AST_UPDN_LOAD: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_UPDN && updn_load && pwrup_o) |=> gain_o == $past(updn_gain)); // R6

    AST_PWR_FORCE: assert property (@(posedge clk) disable iff (rst)
        !pwrup_o |=> gain_o == {GAIN_W{1'b1}}); // R8

    AST_HOLD_NO_UPD: assert property (@(posedge clk) disable iff (rst)
        (no_upd && pwrup_o && $past(pwrup_o)) |=> $stable(gain_o)); // R7
endmodule

bind gain_iface_sel gain_iface_sel_chk #(.GAIN_W(GAIN_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src       (src_s),
    .par_upd   (par_upd),
    .spi_load  (spi_load),
    .spi_gain  (spi_gain),
    .updn_load (updn_load),
    .updn_gain (updn_gain),
    .pwrup_o   (pwrup_o),
    .gain_o    (gain_o)
);

// File: tb/gain_iface_sel_test.sv
`timescale 1ns/1ps
module gain_iface_sel_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_pins = 2'b00;
    logic [6:0] shared_pins = '0;
    logic       pm_pin = 1'b0;
    logic       pwup_pin = 1'b0;
    logic [5:0] spi_gain = '0;
    logic       spi_load = 1'b0;
    logic [5:0] updn_gain = '0;
    logic       updn_load = 1'b0;
    logic [5:0] gain_o;
    logic [2:0] spi_pins_o;
    logic [3:0] updn_pins_o;
    logic       lowpwr_o;
    logic       pwrup_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gain_iface_sel uut (
        .clk         (clk),
        .rst         (rst),
        .mode_pins   (mode_pins),
        .shared_pins (shared_pins),
        .pm_pin      (pm_pin),
        .pwup_pin    (pwup_pin),
        .spi_gain    (spi_gain),
        .spi_load    (spi_load),
        .updn_gain   (updn_gain),
        .updn_load   (updn_load),
        .gain_o      (gain_o),
        .spi_pins_o  (spi_pins_o),
        .updn_pins_o (updn_pins_o),
        .lowpwr_o    (lowpwr_o),
        .pwrup_o     (pwrup_o)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic spi_pulse(input logic [5:0] v);
        spi_gain = v; spi_load = 1'b1;
        step(1);
        spi_load = 1'b0;
    endtask

    task automatic updn_pulse(input logic [5:0] v);
        updn_gain = v; updn_load = 1'b1;
        step(1);
        updn_load = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(3);
        // R10 reset state
        check("R10 gain", gain_o, 6'h3F);
        check("R10 spi_pins", spi_pins_o, 0);
        check("R10 updn_pins", updn_pins_o, 0);
        check("R10 lowpwr", lowpwr_o, 0);
        check("R10 pwrup", pwrup_o, 0);
        rst = 1'b0;
        pwup_pin = 1'b1;
        step(4);

        // R2 transparent sweep with exact latency
        for (int v = 0; v < 64; v++) begin
            shared_pins = {1'b0, v[5:0]};
            step(3);
            if (v > 0) check("R2 not early", gain_o, v - 1);
            step(1);
            check("R2 follow", gain_o, v);
        end

        // R3 latch capture and hold; R1 foreign strobes ignored
        for (int k = 0; k < 8; k++) begin
            logic [5:0] a;
            logic [5:0] b;
            a = 6'(k * 9 + 3);
            b = ~a;
            shared_pins = {1'b0, b};
            step(4);
            shared_pins = {1'b1, a};       // rise together with new value
            step(4);
            check("R3 capture", gain_o, a);
            shared_pins = {1'b1, b};
            step(5);
            check("R3 hold", gain_o, a);
            spi_pulse(6'h2A);
            updn_pulse(6'h15);
            step(1);
            check("R1 par ignores strobes", gain_o, a);
            shared_pins = {1'b0, b};
            step(4);
            check("R3 release", gain_o, b);
        end

        // R4 routing sweep over every mode and pin pattern
        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 128; p++) begin
                mode_pins = 2'(m);
                shared_pins = 7'(p);
                step(2);
                check("R4 spi route", spi_pins_o, (m == 1) ? (p & 7) : 0);
                check("R4 updn route", updn_pins_o, (m >= 2) ? (p & 15) : 0);
            end
        end

        // R5 serial loads; R1 pins ignored in serial mode
        mode_pins = 2'b01;
        step(3);
        for (int v = 0; v < 64; v++) begin
            spi_pulse(6'(v));
            check("R5 load", gain_o, v);
        end
        shared_pins = 7'h55;
        updn_pulse(6'h01);
        step(4);
        check("R1 spi ignores pins/updn", gain_o, 63);

        // R6 up/down loads in both mode codes; R1 serial strobe ignored
        for (int m = 2; m < 4; m++) begin
            mode_pins = 2'(m);
            step(3);
            for (int v = 0; v < 64; v++) begin
                updn_pulse(6'(63 - v));
                check("R6 load", gain_o, 63 - v);
            end
            spi_pulse(6'h3E);
            shared_pins = 7'h2B;
            step(4);
            check("R1 updn ignores spi", gain_o, 0);
        end

        // R7 mode change holds last code
        mode_pins = 2'b01;
        step(3);
        spi_pulse(6'h15);
        shared_pins = {1'b1, 6'h09};
        step(4);
        mode_pins = 2'b00;
        step(6);
        check("R7 hold after to-par", gain_o, 6'h15);
        shared_pins = {1'b0, 6'h09};
        step(4);
        check("R7 par updates", gain_o, 6'h09);
        mode_pins = 2'b10;
        shared_pins = 7'h66;
        step(6);
        check("R7 hold after to-updn", gain_o, 6'h09);
        updn_pulse(6'h33);
        check("R7 updn updates", gain_o, 6'h33);

        // R8 power-down forcing and retention
        pwup_pin = 1'b0;
        step(2);
        check("R8 not yet forced", gain_o, 6'h33);
        step(1);
        check("R8 forced", gain_o, 6'h3F);
        updn_pulse(6'h0C);
        check("R8 forced during load", gain_o, 6'h3F);
        pwup_pin = 1'b1;
        step(3);
        check("R8 retained", gain_o, 6'h0C);
        mode_pins = 2'b00;
        shared_pins = {1'b0, 6'h21};
        step(6);
        pwup_pin = 1'b0;
        step(4);
        check("R8 forced par", gain_o, 6'h3F);
        pwup_pin = 1'b1;
        step(4);
        check("R8 par restore", gain_o, 6'h21);

        // R9 power pins in every mode, exact two-edge latency
        for (int m = 0; m < 4; m++) begin
            mode_pins = 2'(m);
            step(3);
            pm_pin = 1'b1;
            step(1);
            check("R9 pm early", lowpwr_o, 0);
            step(1);
            check("R9 pm high", lowpwr_o, 1);
            pm_pin = 1'b0;
            pwup_pin = 1'b0;
            step(2);
            check("R9 pm low", lowpwr_o, 0);
            check("R9 pwrup low", pwrup_o, 0);
            pwup_pin = 1'b1;
            step(2);
            check("R9 pwrup high", pwrup_o, 1);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule